// File: doc/BRIEF.md
# Half-to-single float widening converter

This block turns a 16-bit binary16 floating-point operand into the 32-bit binary32 value that represents the same number. A producer presents an operand together with a valid strobe. One clock later the widened word appears with its own valid strobe. Widening is always exact, so the block has no rounding mode and raises no flags.

The interesting case is the half subnormal. Every binary16 subnormal lies inside the normal range of binary32. The block therefore renormalises it in a single cycle: a leading-zero count over the 10-bit fraction sets both the left-shift amount and the exponent reduction. NaNs keep their payload in the upper fraction bits and get ones in the 13 padding bits below it. Infinities and signed zeros pass through with their sign.

Top module: `h2s_widen`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_data` are 0, and they stay 0 until an operand is accepted after reset.
- R2: `out_valid` in any cycle equals `in_valid` of the previous cycle; the latency is exactly one clock.
- R3: When `in_valid` is low, `out_data` keeps its previous value.
- R4: Output bit 31 (sign) equals input bit 15 of the accepted operand, for every encoding.
- R5: The input has its exponent in bits 14:10 and its fraction in bits 9:0. For an exponent field of 1..30, the output exponent (bits 30:23) is that field plus 112, and the output fraction (bits 22:0) is the input fraction followed by 13 zero bits.
- R6: An exponent field of 0 with a fraction of 0 gives output bits 30:0 all zero, with the sign kept.
- R7: An exponent field of 0 with a nonzero fraction gives a normal output. Let z be the number of leading zeros of the 10-bit fraction (0..9). The output exponent is 112 − z. The output fraction holds the input fraction shifted left by z+1 within 10 bits, followed by 13 zero bits.
- R8: An exponent field of 31 with a fraction of 0 gives output exponent 0xFF and output fraction 0.
- R9: An exponent field of 31 with a nonzero fraction gives output exponent 0xFF and output fraction bits 22:13 equal to the input fraction, with bits 12:0 all one.
- R10: A nonzero finite input never yields an output exponent of 0 or 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 16 | Binary16 operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 32 | Binary32 result |

## Verification
The bench drives every one of the 65536 half encodings and compares each result with an iterative model that shifts until the hidden bit appears. This covers all ten subnormal shift distances. An off-by-one leading-zero count or shifter stage would give those operands an exponent one step off and a fraction doubled or halved. The NaN encodings would show a zero padding field if the fill were missing, and the boundary exponents 1 and 30 would expose a wrong re-bias constant. Idle cycles are mixed into the sweep, and a reset is applied in the middle of the run, so a result register that loaded without the strobe, or a strobe that did not clear, turns up as a mismatch.

// File: rtl/h2s_pkg.sv
package h2s_pkg;

  localparam int HALF_EXP_W  = 5;
  localparam int HALF_FRAC_W = 10;
  localparam int HALF_W      = 1 + HALF_EXP_W + HALF_FRAC_W;
  localparam int HALF_BIAS   = (1 << (HALF_EXP_W - 1)) - 1;

  localparam int SGL_EXP_W   = 8;
  localparam int SGL_FRAC_W  = 23;
  localparam int SGL_W       = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int SGL_BIAS    = (1 << (SGL_EXP_W - 1)) - 1;

  localparam int PAD_W       = SGL_FRAC_W - HALF_FRAC_W;
  localparam int REBIAS      = SGL_BIAS - HALF_BIAS;
  localparam int LZ_W        = $clog2(HALF_FRAC_W + 1);

  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_SUBNORM = 2'd1,
    CLS_NORMAL  = 2'd2,
    CLS_SPECIAL = 2'd3
  } fp_class_e;

  typedef struct packed {
    logic                   sign;
    logic [HALF_EXP_W-1:0]  exp;
    logic [HALF_FRAC_W-1:0] frac;
  } half_t;

  typedef struct packed {
    logic                  sign;
    logic [SGL_EXP_W-1:0]  exp;
    logic [SGL_FRAC_W-1:0] frac;
  } single_t;

endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
  import h2s_pkg::*;
(
  input  logic [HALF_W-1:0]      op,
  output half_t                  fields,
  output fp_class_e              cls,
  output logic                   frac_nz
);

  logic exp_zero;
  logic exp_ones;

  always_comb begin
    fields   = half_t'(op);
    exp_zero = (fields.exp == '0);
    exp_ones = (fields.exp == '1);
    frac_nz  = (fields.frac != '0);
    if (exp_ones)
      cls = CLS_SPECIAL;
    else if (exp_zero && frac_nz)
      cls = CLS_SUBNORM;
    else if (exp_zero)
      cls = CLS_ZERO;
    else
      cls = CLS_NORMAL;
  end

endmodule

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
  parameter int W  = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);

  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i])
        count = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/h2s_lshift.sv
module h2s_lshift #(
  parameter int W  = 10,
  parameter int SW = 4
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stage [0:SW];

  assign stage[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign stage[k+1] = amt[k] ? (stage[k] << (2 ** k)) : stage[k];
  end

  assign dout = stage[SW];

endmodule

// File: rtl/h2s_assemble.sv
module h2s_assemble
  import h2s_pkg::*;
(
  input  half_t                  fields,
  input  fp_class_e              cls,
  input  logic                   frac_nz,
  input  logic [LZ_W-1:0]        lead_zeros,
  input  logic [HALF_FRAC_W-1:0] sub_frac,
  output single_t                result
);

  localparam logic [SGL_EXP_W-1:0] REBIAS_C = SGL_EXP_W'(REBIAS);
  localparam logic [PAD_W-1:0]     PAD_ONES = '1;

  logic [SGL_EXP_W-1:0] exp_norm;
  logic [SGL_EXP_W-1:0] exp_sub;

  always_comb begin
    exp_norm = SGL_EXP_W'(fields.exp) + REBIAS_C;
    exp_sub  = REBIAS_C - SGL_EXP_W'(lead_zeros);
    result.sign = fields.sign;
    unique case (cls)
      CLS_ZERO: begin
        result.exp  = '0;
        result.frac = '0;
      end
      CLS_SUBNORM: begin
        result.exp  = exp_sub;
        result.frac = {sub_frac, {PAD_W{1'b0}}};
      end
      CLS_NORMAL: begin
        result.exp  = exp_norm;
        result.frac = {fields.frac, {PAD_W{1'b0}}};
      end
      default: begin
        result.exp  = '1;
        result.frac = frac_nz ? {fields.frac, PAD_ONES} : '0;
      end
    endcase
  end

endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
  import h2s_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [HALF_W-1:0] in_data,
  output logic              out_valid,
  output logic [SGL_W-1:0]  out_data
);

  half_t                  fields;
  fp_class_e              cls;
  logic                   frac_nz;
  logic [LZ_W-1:0]        lead_zeros;
  logic [LZ_W-1:0]        shamt;
  logic [HALF_FRAC_W-1:0] sub_frac;
  single_t                widened;

  logic                   valid_q, valid_d;
  logic [SGL_W-1:0]       data_q,  data_d;

  h2s_classify u_classify (
    .op      (in_data),
    .fields  (fields),
    .cls     (cls),
    .frac_nz (frac_nz)
  );

  h2s_lzc #(.W(HALF_FRAC_W)) u_lzc (
    .vec   (fields.frac),
    .count (lead_zeros)
  );

  assign shamt = lead_zeros + LZ_W'(1);

  h2s_lshift #(.W(HALF_FRAC_W), .SW(LZ_W)) u_lshift (
    .din  (fields.frac),
    .amt  (shamt),
    .dout (sub_frac)
  );

  h2s_assemble u_assemble (
    .fields     (fields),
    .cls        (cls),
    .frac_nz    (frac_nz),
    .lead_zeros (lead_zeros),
    .sub_frac   (sub_frac),
    .result     (widened)
  );

  always_comb begin
    valid_d = in_valid;
    data_d  = data_q;
    if (in_valid)
      data_d = SGL_W'(widened);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

endmodule

// File: rtl/h2s_widen_chk.sv
module h2s_widen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_data,
  input logic        out_valid,
  input logic [31:0] out_data
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(in_valid)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(in_valid)) |-> $stable(out_data));

  assert_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid)) |-> (out_data[31] == $past(in_data[15])));

  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid) && ($past(in_data[14:0]) == 15'd0))
      |-> (out_data[30:0] == 31'd0));

  assert_nan_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid) && ($past(in_data[14:10]) == 5'h1f)
       && ($past(in_data[9:0]) != 10'd0))
      |-> ((out_data[30:23] == 8'hff) && (out_data[12:0] == 13'h1fff)));

  assert_exp_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid) && ($past(in_data[14:0]) != 15'd0)
       && ($past(in_data[14:10]) != 5'h1f))
      |-> ((out_data[30:23] != 8'h00) && (out_data[30:23] != 8'hff)));

endmodule

bind h2s_widen h2s_widen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/h2s_widen_bench.sv
`timescale 1ns/1ps
module h2s_widen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        out_valid;
  logic [31:0] out_data;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  bit          model_v;
  logic [31:0] model_d;
  string       model_tag;
  logic [15:0] last_in;

  always #2.5 clk = ~clk;

  h2s_widen u_h2s_widen (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [31:0] ref_widen(input logic [15:0] h);
    int  e = int'(h[14:10]);
    int  f = int'(h[9:0]);
    int  ex;
    logic s = h[15];
    if (e == 0 && f == 0) return {s, 31'd0};
    if (e == 31) begin
      if (f == 0) return {s, 8'hff, 23'd0};
      return {s, 8'hff, 23'(f * 8192 + 8191)};
    end
    if (e == 0) begin
      ex = -14;
      while (f < 1024) begin
        f  = f * 2;
        ex = ex - 1;
      end
      f = f - 1024;
      return {s, 8'(ex + 127), 23'(f * 8192)};
    end
    return {s, 8'(e - 15 + 127), 23'(f * 8192)};
  endfunction

  function automatic string tag_of(input logic [15:0] h);
    if (h[14:10] == 5'h1f) return (h[9:0] == 0) ? "R8" : "R9";
    if (h[14:10] == 5'h00) return (h[9:0] == 0) ? "R6" : "R7";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_cycle();
    check(out_valid == model_v, "R2", 32'(out_valid), 32'(model_v));
    check(out_data == model_d, model_tag, out_data, model_d);
    if (model_v) begin
      check(out_data[31] == last_in[15], "R4",
            32'(out_data[31]), 32'(last_in[15]));
      if (last_in[14:0] != 0 && last_in[14:10] != 5'h1f)
        check(out_data[30:23] != 8'h00 && out_data[30:23] != 8'hff, "R10",
              32'(out_data[30:23]), 32'(model_d[30:23]));
    end
  endtask

  task automatic drive(input bit v, input logic [15:0] d);
    @(negedge clk);
    compare_cycle();
    in_valid = v;
    in_data  = d;
    if (v) begin
      model_v   = 1'b1;
      model_d   = ref_widen(d);
      model_tag = tag_of(d);
      last_in   = d;
    end else begin
      model_v   = 1'b0;
      model_tag = "R3";
    end
  endtask

  task automatic apply_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    #1;
    check(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);
    check(out_data == 32'd0, "R1", out_data, 32'd0);
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);
    rst_n     = 1'b1;
    model_v   = 1'b0;
    model_d   = '0;
    model_tag = "R1";
    last_in   = '0;
  endtask

  initial begin
    apply_reset();
    for (int i = 0; i < 65536; i++) begin
      if (i % 97 == 0) drive(1'b0, 16'hbeef);
      if (i == 30000) begin
        @(negedge clk);
        compare_cycle();
        apply_reset();
      end
      drive(1'b1, 16'(i));
    end
    drive(1'b0, 16'h0000);
    drive(1'b0, 16'h7fff);
    drive(1'b0, 16'h0000);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule